// File: doc/BRIEF.md
# Register-Programmed Byte SPI Master

This block is a serial peripheral master that sits on a simple processor register bus. Software reaches it through two 32-bit words. The control/status word at byte offset 0x0 holds three chip-select levels, a loopback switch, a five-bit clock-divider field and a start/busy bit. The data word at byte offset 0x4 holds the byte to send. After a transfer, the same data word returns the byte that was received.

A control write with the start bit set shifts the low data byte out in SPI mode 0, most significant bit first. While the byte goes out, a byte comes in on the serial input, or from the transmitted stream when loopback is on. Software polls the busy bit and then reads the received byte. Chip selects are plain register bits, so software frames multi-byte transactions itself. A control write made during a transfer is held back until the byte finishes.

Top module: `spi_byte_master`

## Requirements
- R1: The control word is at byte address 0x0 and the data word at 0x4. Other addresses read 0 and ignore writes. After reset the control word reads 0x0000_0015, all chip-select outputs are high and the serial clock is low.
- R2: A control write with bit 1 set, made while idle, starts a one-byte transfer of data bits 7:0. Control bit 1 reads 1 from the next cycle until the byte completes.
- R3: Chip-select output n (n = 0..2) follows control bit 2n, and that bit reads back at the same position.
- R4: Control bits 31:27 hold a divider value F. The serial clock period is 2*(F+1) reference clock cycles, so F = 0 gives half the reference rate.
- R5: A control write with bit 1 clear updates only the chip-select, loopback and divider settings. It produces no serial clock edges and does not set busy.
- R6: The serial clock idles low and gives exactly 8 rising edges per transfer. The serial output is valid before the first rising edge and changes only after falling edges, most significant bit first. The serial input is sampled on rising edges.
- R7: With control bit 3 set, the received byte equals the transmitted byte regardless of the serial input.
- R8: Once busy clears, the data word reads the byte received during that transfer.
- R9: A control write made while busy leaves the outputs and the control readback unchanged until the byte completes, and then takes effect. A start bit in that write is ignored.
- R10: Data word bits 31:8 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus write strobe qualifier |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select levels |

## Verification
Bytes go out in random pairs: a transmitted byte and a different byte answered by a bench slave model. These run at random small dividers, with loopback on or off. If the serial bit order, the sampling edge or the input source were wrong, the two bytes would end up swapped or mangled. Fixed cases use the largest divider and a settings-only write. A write landing mid-transfer that also carries a start bit separates deferred settings from settings applied at once, and an ignored start from a second transfer. An all-ones data write exposes any upper data bits that are stored by mistake.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
   localparam int CTRL_W    = 32;
   localparam int NUM_CS    = 3;
   localparam int DIV_W     = 5;
   localparam int DIV_LSB   = 27;
   localparam int START_BIT = 1;
   localparam int LOOP_BIT  = 3;
   localparam logic [2:0] CTRL_ADDR = 3'h0;
   localparam logic [2:0] DATA_ADDR = 3'h4;

   typedef struct packed {
      logic [DIV_W-1:0]  div;
      logic              loop;
      logic [NUM_CS-1:0] cs;
   } spi_cfg_t;

   localparam spi_cfg_t CFG_RESET = '{div: '0, loop: 1'b0, cs: '1};

   function automatic spi_cfg_t cfg_from_word(input logic [CTRL_W-1:0] w);
      spi_cfg_t c;
      c.div  = w[DIV_LSB +: DIV_W];
      c.loop = w[LOOP_BIT];
      for (int n = 0; n < NUM_CS; n++) c.cs[n] = w[2*n];
      return c;
   endfunction
endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R4: the half-period counter never passes the programmed limit
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int BYTE_W      = 8,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              loop_en,
   input  logic              tick,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_w
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   logic              busy_q, sclk_q;
   logic [BYTE_W-1:0] tx_q, rx_q;
   logic [CNT_W-1:0]  bit_q;
   logic              in_bit;

   generate
      if (LOOPBACK_EN) begin : g_loop
         assign in_bit = loop_en ? tx_q[BYTE_W-1] : miso;
      end else begin : g_noloop
         logic unused_loop;
         assign unused_loop = loop_en;
         assign in_bit = miso;
      end
   endgenerate

   assign done    = busy_q && tick && sclk_q && (bit_q == LAST);
   assign sclk    = sclk_q;
   assign mosi    = tx_q[BYTE_W-1];
   assign busy    = busy_q;
   assign rx_byte = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         tx_q   <= tx_byte;
         bit_q  <= '0;
      end else if (busy_q && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[BYTE_W-2:0], in_bit};
         end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
            if (bit_q == LAST) busy_q <= 1'b0;
         end
      end
   end

   // R6: clock idles low
   a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);
   // R6: data out moves only after a falling edge
   a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$fell(sclk_q)) |-> $stable(mosi));
   // R2: busy only rises on a start request
   a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
   import spi_master_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [CTRL_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic [BYTE_W-1:0] rx_byte,
   output spi_cfg_t          cfg,
   output logic              start,
   output logic [BYTE_W-1:0] tx_byte
);
   generate
      if (DIV_LSB + DIV_W > CTRL_W) begin : g_bad_div
         $error("divider field exceeds control word");
      end
      if (2*NUM_CS - 2 >= DIV_LSB) begin : g_bad_cs
         $error("chip-select bits collide with divider field");
      end
      if (BYTE_W > CTRL_W) begin : g_bad_byte
         $error("BYTE_W exceeds word width");
      end
   endgenerate

   logic wr_ctrl, wr_data;
   spi_cfg_t cfg_q, pend_cfg_q;
   logic pend_q;
   logic [BYTE_W-1:0] data_q;
   spi_cfg_t wr_cfg;
   logic unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_ctrl = bus_en && bus_we && (bus_addr == CTRL_ADDR);
   assign wr_data = bus_en && bus_we && (bus_addr == DATA_ADDR);
   assign wr_cfg  = cfg_from_word(bus_wdata);
   assign start   = wr_ctrl && bus_wdata[START_BIT] && !busy;
   assign cfg     = cfg_q;
   assign tx_byte = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= CFG_RESET;
         pend_cfg_q <= CFG_RESET;
         pend_q     <= 1'b0;
      end else if (done) begin
         pend_q <= 1'b0;
         if (wr_ctrl)      cfg_q <= wr_cfg;
         else if (pend_q)  cfg_q <= pend_cfg_q;
      end else if (wr_ctrl) begin
         if (busy) begin
            pend_q     <= 1'b1;
            pend_cfg_q <= wr_cfg;
         end else begin
            cfg_q <= wr_cfg;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (done)    data_q <= rx_byte;
      else if (wr_data) data_q <= bus_wdata[BYTE_W-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_ADDR) begin
         bus_rdata[DIV_LSB +: DIV_W] = cfg_q.div;
         bus_rdata[LOOP_BIT]         = cfg_q.loop;
         bus_rdata[START_BIT]        = busy;
         for (int n = 0; n < NUM_CS; n++) bus_rdata[2*n] = cfg_q.cs[n];
      end else if (bus_addr == DATA_ADDR) begin
         bus_rdata[BYTE_W-1:0] = data_q;
      end
   end

   // R9: settings stay frozen for the whole byte
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_q));
   // R10: upper data bits never read back
   a_r10_data_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == DATA_ADDR) |-> (bus_rdata[CTRL_W-1:BYTE_W] == '0));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_master_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [CTRL_W-1:0] bus_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_o
);
   spi_cfg_t          cfg;
   logic              start, busy, done, tick;
   logic [BYTE_W-1:0] tx_byte, rx_byte;

   spi_ctrl_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .rx_byte(rx_byte),
      .cfg(cfg), .start(start), .tx_byte(tx_byte));

   spi_sck_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .limit(cfg.div), .tick(tick));

   spi_shift_engine #(.BYTE_W(BYTE_W), .LOOPBACK_EN(LOOPBACK_EN)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
      .loop_en(cfg.loop), .tick(tick), .miso(miso), .sclk(sclk),
      .mosi(mosi), .busy(busy), .done(done), .rx_byte(rx_byte));

   assign cs_o = cfg.cs;

   // R3/R9: select lines do not move in the middle of a byte
   a_r3_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cs_o));
endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'h0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        sclk, mosi, miso;
   logic [2:0]  cs_o;

   spi_byte_master dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;

   // slave model: answers with slv_tx, captures on rising clock
   logic [7:0] slv_tx = '0, slv_rx = '0;
   assign miso = slv_tx[7];
   always @(negedge sclk) slv_tx <= {slv_tx[6:0], 1'b0};
   always @(posedge sclk) slv_rx <= {slv_rx[6:0], mosi};

   // edge monitor sampled at falling reference clock
   int rises = 0, since = 0, bad_period = 0, exp_period = 2;
   logic sclk_prev = 1'b0;
   always @(negedge clk) begin
      since++;
      if (sclk && !sclk_prev) begin
         if (rises > 0 && since != exp_period) bad_period++;
         rises++;
         since = 0;
      end
      sclk_prev = sclk;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cyc, WATCHDOG);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] r;
      for (int i = 0; i < 4000; i++) begin
         bus_read(3'h0, r);
         if (!r[1]) break;
      end
   endtask

   function automatic logic [31:0] ctrl_word(input int div, input bit loop, input logic [2:0] cs, input bit go);
      return (32'(div) << 27) | (32'(loop) << 3) | (32'(go) << 1)
             | 32'(cs[0]) | (32'(cs[1]) << 2) | (32'(cs[2]) << 4);
   endfunction

   task automatic do_xfer(input int div, input bit loop, input logic [7:0] tx, input logic [7:0] sb);
      logic [31:0] r;
      bus_write(3'h4, {24'h0, tx});
      slv_tx = sb;
      rises = 0; bad_period = 0; exp_period = 2*(div+1);
      bus_write(3'h0, ctrl_word(div, loop, 3'b110, 1'b1));
      bus_read(3'h0, r);
      chk("R2 busy while shifting", {31'h0, r[1]}, 32'h1);
      wait_idle();
      bus_read(3'h4, r);
      chk("R8/R7 received byte", r, {24'h0, loop ? tx : sb});
      chk("R6 rising edge count", rises, 8);
      chk("R4 clock period", bad_period, 0);
      if (!loop) chk("R6 slave saw MSB-first byte", {24'h0, slv_rx}, {24'h0, tx});
      chk("R6 clock idle low", {31'h0, sclk}, 32'h0);
   endtask

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5a17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      bus_read(3'h0, r);
      chk("R1 reset control word", r, 32'h15);
      chk("R1 reset selects", {29'h0, cs_o}, 32'h7);
      chk("R1 reset sclk", {31'h0, sclk}, 32'h0);
      bus_read(3'h4, r);
      chk("R1 reset data word", r, 32'h0);

      // R3/R5 settings-only write
      rises = 0;
      bus_write(3'h0, ctrl_word(2, 1'b0, 3'b101, 1'b0));
      repeat (10) @(negedge clk);
      bus_read(3'h0, r);
      chk("R5 control readback, no busy", r, ctrl_word(2, 1'b0, 3'b101, 1'b0));
      chk("R3 select outputs", {29'h0, cs_o}, 32'h5);
      chk("R5 no clock edges", rises, 0);

      // R1 unmapped address
      bus_write(3'h2, 32'hFFFF_FFFF);
      bus_read(3'h2, r);
      chk("R1 unmapped reads zero", r, 32'h0);
      bus_read(3'h0, r);
      chk("R1 unmapped write ignored", r, ctrl_word(2, 1'b0, 3'b101, 1'b0));

      // R10 upper data bits
      bus_write(3'h4, 32'hFFFF_FFA5);
      bus_read(3'h4, r);
      chk("R10 data upper bits zero", r, 32'hA5);

      // directed corners
      do_xfer(0, 1'b0, 8'h80, 8'h01);
      do_xfer(31, 1'b0, 8'hC3, 8'h5A);
      do_xfer(1, 1'b1, 8'h96, 8'hFF);

      // random mix
      for (int i = 0; i < 20; i++)
         do_xfer(int'($urandom % 4), bit'($urandom % 2), 8'($urandom), 8'($urandom));

      // R9 deferred write with ignored start
      bus_write(3'h4, 32'h3C);
      slv_tx = 8'hE1;
      rises = 0; bad_period = 0; exp_period = 8;
      bus_write(3'h0, ctrl_word(3, 1'b0, 3'b111, 1'b1));
      repeat (5) @(negedge clk);
      bus_write(3'h0, ctrl_word(1, 1'b1, 3'b000, 1'b1));
      chk("R9 selects held mid-byte", {29'h0, cs_o}, 32'h7);
      bus_read(3'h0, r);
      chk("R9 readback held mid-byte", r, ctrl_word(3, 1'b0, 3'b111, 1'b1));
      wait_idle();
      chk("R9 selects applied after byte", {29'h0, cs_o}, 32'h0);
      repeat (20) @(negedge clk);
      bus_read(3'h0, r);
      chk("R9 deferred settings, start ignored", r, ctrl_word(1, 1'b1, 3'b000, 1'b0));
      chk("R9 only one byte shifted", rises, 8);
      bus_read(3'h4, r);
      chk("R8 byte from first transfer", r, 32'hE1);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule